// File: doc/BRIEF.md
# Write-Only Control Register Target for a Video Filter Buffer

This block is a two-wire serial bus (I2C) target that only accepts writes. It keeps four one-byte control registers for an analog video filter and output buffer, and it turns their contents into control fields. The fields are a cutoff code, six clamp/bias input selects, a filter bypass flag, a power-down flag, a half-cutoff mode flag and two signed gain codes. The clock and data lines arrive already synchronized to the system clock. The block drives the data line only through an open-drain pull-low enable.

A host writes one byte that carries the target address and the write direction. It then writes a register index and one or more data bytes. The index advances after every stored data byte, so a single transaction can fill neighbouring registers. A three-level select input chooses one of three target addresses, so three of these blocks can share one bus. Bytes that fall beyond the last register get no acknowledge. No read path exists.

Top module: `vfb_ctrl_slave`

## Requirements
- R1: The target address follows `addr_sel_i`. The value 2'b00 (low) selects 0x48, 2'b01 (high) selects 0x49, and 2'b10 or 2'b11 (open) selects 0x4A.
- R2: An address byte is not acknowledged, and no register changes until the next START, when its upper seven bits differ from the selected address or its last bit (R/W) is 1.
- R3: In a transaction made of an address byte, an index byte and a data byte, the target pulls SDA low in the ninth clock of each byte, and the data lands in the indexed register.
- R4: Each stored data byte advances the index by one, so consecutive data bytes fill consecutive registers.
- R5: When the index has advanced past 3, any further data byte is neither stored nor acknowledged.
- R6: An index byte above 0x03 is not acknowledged, and the data bytes that follow it store nothing.
- R7: Field layout. Register 0 is the 8-bit cutoff code. Register 1 bits 7:2 are the clamp/bias selects and bit 1 is bypass. Register 2 bit 7 is power-down, bit 6 is half-cutoff and bits 5:0 are the main gain. Register 3 bits 5:0 are the auxiliary gain. Both gains are 6-bit two's complement.
- R8: After reset every field is zero and SDA is released.
- R9: The pull-low enable changes only while SCL is low. It is never asserted during the eight data bits of a byte, and it stays asserted through the whole high phase of an acknowledge clock.
- R10: A START or repeated START in the middle of a byte drops that byte and restarts address reception. A STOP returns the block to idle and leaves every register as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Synchronized bus clock |
| sda_i | input | 1 | Synchronized bus data (wired level) |
| addr_sel_i | input | 2 | Decoded address select: 00 low, 01 high, 1x open |
| sda_pull_o | output | 1 | Open-drain enable; 1 pulls SDA low |
| cutoff_o | output | 8 | Filter cutoff code |
| in_mode_o | output | 6 | Clamp/bias selects, one bit per input pair position |
| bypass_o | output | 1 | Filter bypass |
| pwrdn_o | output | 1 | Power-down |
| half_cut_o | output | 1 | Half-cutoff mode for the second and third channels |
| gain_main_o | output | 6 | Signed gain of the filtered channels |
| gain_aux_o | output | 6 | Signed gain of the fixed-filter channels |

## Verification
Assertions check the line-level rules on every cycle. The pull-low enable may move only while SCL is low and must stay steady across an acknowledge high phase. A START leaves the byte engine at bit zero, a STOP leaves it idle, and no store happens once the index has run off the end. A register that sees no write strobe keeps its value. Other behaviour only shows up at the ports in scenarios the bench builds, because it depends on a whole sequence of bytes: the address chosen by each select level, refusal of reads and foreign addresses, auto-increment across registers, refusal of an out-of-range index, and a byte dropped when a repeated START interrupts it.

// File: rtl/vfbc_pkg.sv
package vfbc_pkg;

  localparam int unsigned DATA_W    = 8;
  localparam int unsigned ADDR_W    = 7;
  localparam int unsigned NREG      = 4;
  localparam int unsigned IDX_W     = $clog2(NREG);
  localparam int unsigned PTR_W     = IDX_W + 1;
  localparam int unsigned BITCNT_W  = $clog2(DATA_W) + 1;

  typedef enum logic [2:0] {
    LS_IDLE,
    LS_RECV,
    LS_ACKSET,
    LS_ACK,
    LS_SKIP
  } link_state_t;

  typedef enum logic [1:0] {
    BK_ADDR,
    BK_SUB,
    BK_DATA
  } byte_kind_t;

endpackage

// File: rtl/vfbc_line_events.sv
module vfbc_line_events (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);

  logic scl_q, sda_q;
  logic scl_d, sda_d;

  always_comb begin
    scl_d = scl_i;
    sda_d = sda_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_d;
      sda_q <= sda_d;
    end
  end

  always_comb begin
    scl_rise = scl_i & ~scl_q;
    scl_fall = ~scl_i & scl_q;
    start_ev = scl_i & scl_q & sda_q & ~sda_i;
    stop_ev  = scl_i & scl_q & ~sda_q & sda_i;
  end

endmodule

// File: rtl/vfbc_link.sv
module vfbc_link
  import vfbc_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sda_i,
  input  logic                scl_rise,
  input  logic                scl_fall,
  input  logic                start_ev,
  input  logic                stop_ev,
  input  logic [ADDR_W-1:0]   own_addr,
  output logic                sda_pull,
  output logic                wr_en,
  output logic [IDX_W-1:0]    wr_idx,
  output logic [DATA_W-1:0]   wr_data
);

  localparam logic [DATA_W-1:0]   LAST_B   = DATA_W'(NREG - 1);
  localparam logic [PTR_W-1:0]    LAST_P   = PTR_W'(NREG - 1);
  localparam logic [BITCNT_W-1:0] LAST_BIT = BITCNT_W'(DATA_W - 1);

  link_state_t          state_q, state_d;
  byte_kind_t           kind_q,  kind_d;
  logic [BITCNT_W-1:0]  cnt_q,   cnt_d;
  logic [DATA_W-2:0]    sh_q,    sh_d;
  logic [PTR_W-1:0]     ptr_q,   ptr_d;
  logic                 ack_q,   ack_d;
  logic                 pull_q,  pull_d;
  logic [DATA_W-1:0]    byte_full;

  assign byte_full = {sh_q, sda_i};

  always_comb begin
    state_d = state_q;
    kind_d  = kind_q;
    cnt_d   = cnt_q;
    sh_d    = sh_q;
    ptr_d   = ptr_q;
    ack_d   = ack_q;
    pull_d  = pull_q;
    wr_en   = 1'b0;
    wr_idx  = ptr_q[IDX_W-1:0];
    wr_data = byte_full;

    if (start_ev) begin
      state_d = LS_RECV;
      kind_d  = BK_ADDR;
      cnt_d   = '0;
      ack_d   = 1'b0;
      pull_d  = 1'b0;
    end else if (stop_ev) begin
      state_d = LS_IDLE;
      pull_d  = 1'b0;
    end else begin
      unique case (state_q)
        LS_RECV: begin
          if (scl_rise) begin
            sh_d  = byte_full[DATA_W-2:0];
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_BIT) begin
              state_d = LS_ACKSET;
              unique case (kind_q)
                BK_ADDR: ack_d = (byte_full[DATA_W-1:1] == own_addr) && !byte_full[0];
                BK_SUB: begin
                  ack_d = (byte_full <= LAST_B);
                  if (byte_full <= LAST_B) ptr_d = byte_full[PTR_W-1:0];
                end
                default: begin
                  if (ptr_q <= LAST_P) begin
                    ack_d = 1'b1;
                    wr_en = 1'b1;
                    ptr_d = ptr_q + 1'b1;
                  end else begin
                    ack_d = 1'b0;
                  end
                end
              endcase
            end
          end
        end
        LS_ACKSET: begin
          if (scl_fall) begin
            pull_d  = ack_q;
            state_d = ack_q ? LS_ACK : LS_SKIP;
          end
        end
        LS_ACK: begin
          if (scl_fall) begin
            pull_d  = 1'b0;
            state_d = LS_RECV;
            cnt_d   = '0;
            kind_d  = (kind_q == BK_ADDR) ? BK_SUB : BK_DATA;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= LS_IDLE;
      kind_q  <= BK_ADDR;
      cnt_q   <= '0;
      sh_q    <= '0;
      ptr_q   <= '0;
      ack_q   <= 1'b0;
      pull_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      kind_q  <= kind_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      ptr_q   <= ptr_d;
      ack_q   <= ack_d;
      pull_q  <= pull_d;
    end
  end

  assign sda_pull = pull_q;

  // R10: a START leaves the byte engine at bit zero with SDA released
  a_r10_start_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (state_q == LS_RECV) && (cnt_q == '0) && !pull_q);

  // R10: a STOP parks the engine
  a_r10_stop_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_ev && !start_ev) |=> (state_q == LS_IDLE) && !pull_q);

  // R5: nothing is stored once the index has run past the last register
  a_r5_no_store_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    (kind_q == BK_DATA && ptr_q > LAST_P) |-> !wr_en);

endmodule

// File: rtl/vfbc_regbank.sv
module vfbc_regbank
  import vfbc_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en,
  input  logic [IDX_W-1:0]               wr_idx,
  input  logic [DATA_W-1:0]              wr_data,
  output logic [NREG-1:0][DATA_W-1:0]    regs_o
);

  logic [DATA_W-1:0] regs_q [NREG];
  logic [DATA_W-1:0] regs_d [NREG];
  logic [NREG-1:0]   sel_en;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    assign sel_en[g] = wr_en && (wr_idx == IDX_W'(g));

    always_comb begin
      regs_d[g] = regs_q[g];
      if (sel_en[g]) regs_d[g] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) regs_q[g] <= '0;
      else        regs_q[g] <= regs_d[g];
    end

    assign regs_o[g] = regs_q[g];

    // R4: a register without its write strobe keeps its contents
    a_r4_hold_unwritten: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && wr_idx == IDX_W'(g)) |=> $stable(regs_q[g]));
  end

endmodule

// File: rtl/vfb_ctrl_slave.sv
module vfb_ctrl_slave
  import vfbc_pkg::*;
#(
  parameter logic [6:0] BASE_ADDR = 7'h48
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       scl_i,
  input  logic       sda_i,
  input  logic [1:0] addr_sel_i,
  output logic       sda_pull_o,
  output logic [7:0] cutoff_o,
  output logic [5:0] in_mode_o,
  output logic       bypass_o,
  output logic       pwrdn_o,
  output logic       half_cut_o,
  output logic [5:0] gain_main_o,
  output logic [5:0] gain_aux_o
);

  logic rst_meta_q, rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  logic [ADDR_W-1:0] own_addr;

  always_comb begin
    if (addr_sel_i[1])      own_addr = BASE_ADDR + 7'd2;
    else if (addr_sel_i[0]) own_addr = BASE_ADDR + 7'd1;
    else                    own_addr = BASE_ADDR;
  end

  logic scl_rise, scl_fall, start_ev, stop_ev;
  logic wr_en;
  logic [IDX_W-1:0] wr_idx;
  logic [DATA_W-1:0] wr_data;
  logic [NREG-1:0][DATA_W-1:0] regs;

  vfbc_line_events u_events (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .scl_i    (scl_i),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev)
  );

  vfbc_link u_link (
    .clk      (clk),
    .rst_n    (rst_sync_q),
    .sda_i    (sda_i),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .own_addr (own_addr),
    .sda_pull (sda_pull_o),
    .wr_en    (wr_en),
    .wr_idx   (wr_idx),
    .wr_data  (wr_data)
  );

  vfbc_regbank u_regs (
    .clk     (clk),
    .rst_n   (rst_sync_q),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .regs_o  (regs)
  );

  assign cutoff_o    = regs[0];
  assign in_mode_o   = regs[1][7:2];
  assign bypass_o    = regs[1][1];
  assign pwrdn_o     = regs[2][7];
  assign half_cut_o  = regs[2][6];
  assign gain_main_o = regs[2][5:0];
  assign gain_aux_o  = regs[3][5:0];

  logic spare_unused;
  assign spare_unused = ^{regs[1][0], regs[3][7:6]};

  // R9: the pull-low enable only moves while SCL is low
  a_r9_pull_moves_scl_low: assert property (@(posedge clk) disable iff (!rst_sync_q)
    !$stable(sda_pull_o) |-> !scl_i);

  // R9: once pulling with SCL high, keep pulling on the next cycle
  a_r9_pull_held_high: assert property (@(posedge clk) disable iff (!rst_sync_q)
    (sda_pull_o && scl_i && !start_ev && !stop_ev) |=> sda_pull_o);

endmodule

// File: tb/tb_vfb_ctrl_slave.sv
module tb_vfb_ctrl_slave;

  localparam int Q = 100;

  logic clk = 1'b0;
  logic rst_n;
  logic scl_m, sda_m;
  logic [1:0] addr_sel;
  logic sda_pull;
  logic [7:0] cutoff;
  logic [5:0] in_mode, gain_main, gain_aux;
  logic bypass, pwrdn, half_cut;
  logic sda_line;

  always #2 clk = ~clk;

  assign sda_line = sda_m & ~sda_pull;

  vfb_ctrl_slave dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .scl_i       (scl_m),
    .sda_i       (sda_line),
    .addr_sel_i  (addr_sel),
    .sda_pull_o  (sda_pull),
    .cutoff_o    (cutoff),
    .in_mode_o   (in_mode),
    .bypass_o    (bypass),
    .pwrdn_o     (pwrdn),
    .half_cut_o  (half_cut),
    .gain_main_o (gain_main),
    .gain_aux_o  (gain_aux)
  );

  int n_chk = 0;
  int n_err = 0;
  logic [7:0] mdl [4];

  typedef struct { bit ack; string tag; } exp_t;
  exp_t exp_q [$];
  event ack_win;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops the expected acknowledge and samples the wired line twice
  initial begin
    forever begin
      exp_t e;
      logic o1, o2;
      @(ack_win);
      e  = exp_q.pop_front();
      o1 = sda_line;
      wq(Q);
      o2 = sda_line;
      chk(o1 == !e.ack, e.tag, "ack level early high phase", int'(o1), int'(!e.ack));
      chk(o2 == !e.ack, e.tag, "ack level late high phase (R9 hold)", int'(o2), int'(!e.ack));
    end
  end

  task automatic bus_start();
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b1; wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic send_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(2 * Q);
      scl_m = 1'b0; wq(Q);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
    bit seen_pull;
    seen_pull = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(Q);
      scl_m = 1'b1; wq(Q);
      if (sda_pull) seen_pull = 1'b1;
      wq(Q);
      scl_m = 1'b0; wq(Q);
    end
    chk(!seen_pull, "R9", "pull during data bits", int'(seen_pull), 0);
    sda_m = 1'b1; wq(Q);
    scl_m = 1'b1; wq(Q / 4);
    exp_q.push_back('{ack: exp_ack, tag: tag});
    -> ack_win;
    wq(2 * Q - Q / 4);
    scl_m = 1'b0; wq(Q);
    chk(sda_pull == 1'b0, "R9", "pull released after ack clock", int'(sda_pull), 0);
  endtask

  task automatic check_regs(input string tag);
    chk(cutoff == mdl[0], tag, "cutoff", cutoff, mdl[0]);
    chk(in_mode == mdl[1][7:2], tag, "in_mode", in_mode, mdl[1][7:2]);
    chk(bypass == mdl[1][1], tag, "bypass", bypass, mdl[1][1]);
    chk(pwrdn == mdl[2][7], tag, "pwrdn", pwrdn, mdl[2][7]);
    chk(half_cut == mdl[2][6], tag, "half_cut", half_cut, mdl[2][6]);
    chk(gain_main == mdl[2][5:0], tag, "gain_main", gain_main, mdl[2][5:0]);
    chk(gain_aux == mdl[3][5:0], tag, "gain_aux", gain_aux, mdl[3][5:0]);
  endtask

  // watchdog
  initial begin
    repeat (195000) @(posedge clk);
    n_chk++;
    n_err++;
    $display("FAIL R3 watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    scl_m = 1'b1;
    sda_m = 1'b1;
    addr_sel = 2'b00;
    for (int i = 0; i < 4; i++) mdl[i] = 8'h00;
    wq(10);
    rst_n = 1'b1;
    wq(10);

    // R8: reset state
    check_regs("R8");
    chk(sda_pull == 1'b0, "R8", "sda released", int'(sda_pull), 0);

    // R3: single write to register 0, select low -> 0x48
    bus_start();
    send_byte({7'h48, 1'b0}, 1'b1, "R1");
    send_byte(8'h00, 1'b1, "R3");
    send_byte(8'hA5, 1'b1, "R3");
    bus_stop();
    mdl[0] = 8'hA5;
    check_regs("R3");

    // R4/R7: burst into registers 1..3, then R5 overflow
    bus_start();
    send_byte({7'h48, 1'b0}, 1'b1, "R1");
    send_byte(8'h01, 1'b1, "R4");
    send_byte(8'hB6, 1'b1, "R4");
    send_byte(8'hE1, 1'b1, "R4");
    send_byte(8'h3F, 1'b1, "R4");
    send_byte(8'h55, 1'b0, "R5");
    bus_stop();
    mdl[1] = 8'hB6; mdl[2] = 8'hE1; mdl[3] = 8'h3F;
    check_regs("R4");
    chk($signed(gain_main) == -31, "R7", "main gain signed", $signed(gain_main), -31);
    chk($signed(gain_aux) == -1, "R7", "aux gain signed", $signed(gain_aux), -1);
    chk(in_mode == 6'h2D && bypass, "R7", "reg1 split", {in_mode, bypass}, {6'h2D, 1'b1});

    // R6: out-of-range index refused, following data ignored
    bus_start();
    send_byte({7'h48, 1'b0}, 1'b1, "R1");
    send_byte(8'h04, 1'b0, "R6");
    send_byte(8'h11, 1'b0, "R6");
    bus_stop();
    check_regs("R6");

    // R1/R2: select high -> 0x48 refused, 0x49 accepted
    addr_sel = 2'b01;
    bus_start();
    send_byte({7'h48, 1'b0}, 1'b0, "R2");
    send_byte(8'h00, 1'b0, "R2");
    bus_stop();
    check_regs("R2");
    bus_start();
    send_byte({7'h49, 1'b0}, 1'b1, "R1");
    send_byte(8'h03, 1'b1, "R1");
    send_byte(8'h1F, 1'b1, "R1");
    bus_stop();
    mdl[3] = 8'h1F;
    check_regs("R1");

    // R1: select open -> 0x4A; R2: read direction refused
    addr_sel = 2'b10;
    bus_start();
    send_byte({7'h4A, 1'b0}, 1'b1, "R1");
    send_byte(8'h00, 1'b1, "R1");
    send_byte(8'h3C, 1'b1, "R1");
    bus_start();
    send_byte({7'h4A, 1'b1}, 1'b0, "R2");
    send_byte(8'hFF, 1'b0, "R2");
    bus_stop();
    mdl[0] = 8'h3C;
    check_regs("R2");

    // R10: repeated START in mid data byte drops it; STOP keeps registers
    bus_start();
    send_byte({7'h4A, 1'b0}, 1'b1, "R10");
    send_byte(8'h02, 1'b1, "R10");
    send_bits(8'h9C, 4);
    bus_start();
    send_byte({7'h4A, 1'b0}, 1'b1, "R10");
    send_byte(8'h00, 1'b1, "R10");
    send_byte(8'h77, 1'b1, "R10");
    bus_stop();
    mdl[0] = 8'h77;
    check_regs("R10");
    wq(4 * Q);
    check_regs("R10");

    wq(2 * Q);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule